// File: doc/BRIEF.md
# Masked Content Addressable Memory

This block stores a small set of fixed-length words and finds them by content rather than by address. A search applies a key to every stored word at once. A mask register chooses which bit positions form the key field. Each word drives its own match flag, and a fixed-order selector then picks the lowest-index matching word and reads out its data. When more than one word matches, a next-match strobe steps through the remaining matches in ascending index order.

The same mask register also guards writes. A write chooses one word by address and changes only the bit positions that the mask includes. Positions outside the key field keep their stored value. Each word carries a valid flag that its first write sets. Words that have never been written take no part in any search.

All request pins are single-cycle strobes. The block accepts every strobe in the cycle it is presented, so there is no back-pressure on writes, mask loads, searches or next-match steps. Results come from registers and hold until the next search or next-match strobe changes them.

Top module: `mask_cam`

## Requirements
- R1: After reset no word is valid, the mask is all ones, srch_hit is 0 and srch_match_vec is all zeros.
- R2: A cycle with mask_ld=1 loads mask_in into the mask. A mask bit of 1 puts that bit position into the key field and lets writes change it. A mask bit of 0 leaves the position out of both.
- R3: Word i changes only in a cycle with wr_en=1 and wr_addr=i. That write sets the word's valid flag. With wr_en=0, no word changes.
- R4: A write leaves every bit position whose mask bit is 0 at its previous stored value. Every position whose mask bit is 1 takes the value of wr_data.
- R5: A cycle with srch_en=1 compares srch_key with all words at once. Word i matches when it is valid and equals the key at every position whose mask bit is 1. Bit i of srch_match_vec shows word i's result from the cycle after the strobe.
- R6: A word that has never been written never matches, whatever the key and the mask.
- R7: With an all-zero mask, every valid word matches.
- R8: srch_hit is 1 while any reported match is pending. srch_idx is the lowest pending index, and srch_data is that word's current contents. srch_data is 0 when srch_hit is 0.
- R9: A cycle with srch_nxt=1 and srch_hit=1 removes the reported index from the pending set, so the next-lowest match is reported from the following cycle. srch_hit falls after the last match. srch_nxt with srch_hit=0 has no effect, and srch_match_vec does not change.
- R10: A write and a search in the same cycle: the search result reflects the contents from before that write.
- R11: srch_en and srch_nxt in the same cycle: the new search result replaces the pending set, and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_ld | input | 1 | Load strobe for the mask register |
| mask_in | input | WIDTH | New mask value (1 = in key and writable) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | IDXW | Index of the word to write |
| wr_data | input | WIDTH | Data to write under the mask |
| srch_en | input | 1 | Search strobe |
| srch_key | input | WIDTH | Search key |
| srch_nxt | input | 1 | Advance to the next pending match |
| srch_match_vec | output | WORDS | Per-word match result of the last search |
| srch_hit | output | 1 | A match is pending |
| srch_idx | output | IDXW | Lowest pending matching index |
| srch_data | output | WIDTH | Contents of the word at srch_idx |

## Verification
A wrong valid flag or a corrupt stored bit shows up in the match vector on the first search after it arises. It can also show up in srch_data as soon as that word is reported. A fault in the pending set shows up one cycle after a next-match strobe, as a wrong index, a repeated index or a hit that drops too early. A write that ignores the mask stays hidden until the affected word is read out through a search, so the checks search with a key that exposes the protected positions.

// File: rtl/mask_cam_pkg.sv
package mask_cam_pkg;
  localparam int unsigned DEF_WORDS = 16;
  localparam int unsigned DEF_WIDTH = 32;

  typedef enum logic [1:0] {
    PEND_HOLD = 2'd0,
    PEND_LOAD = 2'd1,
    PEND_STEP = 2'd2
  } pend_op_e;
endpackage

// File: rtl/cam_row.sv
module cam_row #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] key,
  output logic [WIDTH-1:0] word_q,
  output logic             valid_q,
  output logic             match
);
  logic             do_write;
  logic [WIDTH-1:0] bit_eq;

  assign do_write = row_sel & wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else if (do_write) begin
      word_q  <= (word_q & ~mask) | (wr_data & mask);
      valid_q <= 1'b1;
    end
  end

  // per-bit equivalence, masked positions forced to agree
  assign bit_eq = ~(word_q ^ key) | ~mask;
  assign match  = valid_q & (&bit_eq);

  // R4
  masked_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sel && wr_en) |=> ((word_q & ~$past(mask)) == ($past(word_q) & ~$past(mask))));

  // R3
  unselected_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_sel && wr_en) |=> ($stable(word_q) && $stable(valid_q)));
endmodule

// File: rtl/cam_first_sel.sv
module cam_first_sel #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx = IW'(i);
      end
    end
  end

  assign any = |req;

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0) && (any == (grant != '0)));

  // R8
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & (grant - N'(1))) == '0));
endmodule

// File: rtl/cam_pending.sv
module cam_pending
  import mask_cam_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srch_en,
  input  logic         srch_nxt,
  input  logic [N-1:0] match_now,
  input  logic [N-1:0] grant,
  output logic [N-1:0] match_q,
  output logic [N-1:0] pend_q
);
  pend_op_e op;

  always_comb begin
    if (srch_en)                    op = PEND_LOAD;
    else if (srch_nxt && |pend_q)   op = PEND_STEP;
    else                            op = PEND_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
      pend_q  <= '0;
    end else begin
      case (op)
        PEND_LOAD: begin
          match_q <= match_now;
          pend_q  <= match_now;
        end
        PEND_STEP: pend_q <= pend_q & ~grant;
        default: ;
      endcase
    end
  end

  // R9
  pend_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~match_q) == '0));

  // R9
  step_removes_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!srch_en && srch_nxt && (pend_q != '0)) |=>
      (($countones(pend_q) + 1 == $countones($past(pend_q))) && $stable(match_q)));

  // R9
  idle_nxt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!srch_en && (pend_q == '0)) |=> ((pend_q == '0) && $stable(match_q)));
endmodule

// File: rtl/mask_cam.sv
module mask_cam
  import mask_cam_pkg::*;
#(
  parameter int unsigned WORDS = DEF_WORDS,
  parameter int unsigned WIDTH = DEF_WIDTH,
  localparam int unsigned IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_ld,
  input  logic [WIDTH-1:0] mask_in,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             srch_en,
  input  logic [WIDTH-1:0] srch_key,
  input  logic             srch_nxt,
  output logic [WORDS-1:0] srch_match_vec,
  output logic             srch_hit,
  output logic [IDXW-1:0]  srch_idx,
  output logic [WIDTH-1:0] srch_data
);
  logic [WIDTH-1:0] mask_q;
  logic [WORDS-1:0] row_sel;
  logic [WORDS-1:0] row_match;
  logic [WORDS-1:0] row_valid;
  logic [WIDTH-1:0] row_word [WORDS];
  logic [WORDS-1:0] pend;
  logic [WORDS-1:0] grant;
  logic             any_pend;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_ld) mask_q <= mask_in;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_row
    assign row_sel[g] = (wr_addr == IDXW'(g));

    cam_row #(.WIDTH(WIDTH)) row_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .row_sel (row_sel[g]),
      .wr_en   (wr_en),
      .mask    (mask_q),
      .wr_data (wr_data),
      .key     (srch_key),
      .word_q  (row_word[g]),
      .valid_q (row_valid[g]),
      .match   (row_match[g])
    );
  end

  cam_pending #(.N(WORDS)) pend_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .srch_en   (srch_en),
    .srch_nxt  (srch_nxt),
    .match_now (row_match),
    .grant     (grant),
    .match_q   (srch_match_vec),
    .pend_q    (pend)
  );

  cam_first_sel #(.N(WORDS), .IW(IDXW)) sel_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (pend),
    .grant (grant),
    .idx   (srch_idx),
    .any   (any_pend)
  );

  assign srch_hit  = any_pend;
  assign srch_data = any_pend ? row_word[srch_idx] : '0;

  // R6
  invalid_never_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_match & ~row_valid) == '0));

  // R8
  hit_in_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> srch_match_vec[srch_idx]);

  // R5
  search_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> (srch_match_vec == $past(row_match)));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> ((mask_q == '1) && (row_valid == '0) && !srch_hit));
endmodule

// File: tb/mask_cam_tb_top.sv
module mask_cam_tb_top;
  localparam int N  = 16;
  localparam int W  = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mask_ld;
  logic [W-1:0]  mask_in;
  logic          wr_en;
  logic [IW-1:0] wr_addr;
  logic [W-1:0]  wr_data;
  logic          srch_en;
  logic [W-1:0]  srch_key;
  logic          srch_nxt;
  logic [N-1:0]  srch_match_vec;
  logic          srch_hit;
  logic [IW-1:0] srch_idx;
  logic [W-1:0]  srch_data;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] mdl_word [N];
  logic [N-1:0] mdl_valid;
  logic [W-1:0] mdl_mask;
  logic [N-1:0] mdl_pend;

  always #2.5 clk = ~clk;

  mask_cam dut_i (
    .clk(clk), .rst_n(rst_n), .mask_ld(mask_ld), .mask_in(mask_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .srch_en(srch_en), .srch_key(srch_key), .srch_nxt(srch_nxt),
    .srch_match_vec(srch_match_vec), .srch_hit(srch_hit),
    .srch_idx(srch_idx), .srch_data(srch_data)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_vec(input logic [W-1:0] key);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++)
      v[i] = mdl_valid[i] && (((mdl_word[i] ^ key) & mdl_mask) == '0);
    return v;
  endfunction

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk_out(input string req);
    logic hit_e = |mdl_pend;
    int   li    = lowest(mdl_pend);
    chk(req, W'(srch_hit), W'(hit_e));
    if (hit_e) begin
      chk(req, W'(srch_idx), W'(li));
      chk(req, srch_data, mdl_word[li]);
    end else begin
      chk(req, srch_data, '0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mask_ld = 0; mask_in = '0; wr_en = 0; wr_addr = '0;
    wr_data = '0; srch_en = 0; srch_key = '0; srch_nxt = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) mdl_word[i] = '0;
    mdl_valid = '0; mdl_mask = '1; mdl_pend = '0;
  endtask

  task automatic do_write(input int a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = IW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    mdl_word[a] = (mdl_word[a] & ~mdl_mask) | (d & mdl_mask);
    mdl_valid[a] = 1'b1;
  endtask

  task automatic do_mask(input logic [W-1:0] m);
    @(negedge clk);
    mask_ld = 1; mask_in = m;
    @(negedge clk);
    mask_ld = 0;
    mdl_mask = m;
  endtask

  task automatic do_search(input string req, input logic [W-1:0] key);
    logic [N-1:0] e = exp_vec(key);
    @(negedge clk);
    srch_en = 1; srch_key = key;
    @(negedge clk);
    srch_en = 0;
    mdl_pend = e;
    chk(req, W'(srch_match_vec), W'(e));
    chk_out(req);
  endtask

  task automatic do_next(input string req);
    logic [N-1:0] vec_before = srch_match_vec;
    @(negedge clk);
    srch_nxt = 1;
    @(negedge clk);
    srch_nxt = 0;
    if (mdl_pend != '0) mdl_pend[lowest(mdl_pend)] = 1'b0;
    chk(req, W'(srch_match_vec), W'(vec_before));
    chk_out(req);
  endtask

  // R1, R6
  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 hit", W'(srch_hit), '0);
    chk("R1 vec", W'(srch_match_vec), '0);
    do_search("R6 empty", 32'h0);
    do_mask('0);
    do_search("R6 empty zero mask", 32'h1234_5678);
  endtask

  // R3, R5, R8
  task automatic t_basic();
    do_reset();
    do_write(3, 32'hA5A5_0001);
    do_write(7, 32'h0BAD_F00D);
    do_search("R5 single", 32'hA5A5_0001);
    do_search("R8 other", 32'h0BAD_F00D);
    do_search("R5 miss", 32'hA5A5_0002);
    // R3: wr_en low leaves word 3 untouched
    @(negedge clk);
    wr_en = 0; wr_addr = IW'(3); wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    do_search("R3 no enable", 32'hA5A5_0001);
  endtask

  // R2, R4
  task automatic t_masked_write();
    do_reset();
    do_write(4, 32'h1111_2222);
    do_mask(32'h0000_FFFF);
    do_write(4, 32'hFFFF_FFFF);
    do_mask('1);
    do_search("R4 masked kept", 32'h1111_FFFF);
    chk("R4 data", srch_data, 32'h1111_FFFF);
    do_mask(32'hFF00_0000);
    do_search("R2 partial key", 32'h11AB_CDEF);
    do_search("R2 partial miss", 32'h22AB_CDEF);
  endtask

  // R8, R9
  task automatic t_multi();
    do_reset();
    do_write(9, 32'hC0DE_0009);
    do_write(2, 32'hC0DE_0002);
    do_write(5, 32'hC0DE_0005);
    do_write(6, 32'h0000_0006);
    do_mask(32'hFFFF_0000);
    do_search("R8 multi", 32'hC0DE_7777);
    do_next("R9 step1");
    do_next("R9 step2");
    do_next("R9 end");
    chk("R9 drained", W'(srch_hit), '0);
    do_next("R9 idle");
  endtask

  // R7
  task automatic t_zero_mask();
    do_reset();
    do_write(12, 32'h0000_0012);
    do_write(1, 32'h0000_0001);
    do_mask('0);
    do_search("R7 all valid", 32'hDEAD_BEEF);
    chk("R7 vec", W'(srch_match_vec), W'(16'h1002));
  endtask

  // R10, R11
  task automatic t_same_cycle();
    logic [N-1:0] e;
    do_reset();
    do_write(3, 32'h0000_0AAA);
    do_write(8, 32'h0000_0AAA);
    e = exp_vec(32'h0000_0AAA);
    @(negedge clk);
    wr_en = 1; wr_addr = IW'(3); wr_data = 32'h0000_0BBB;
    srch_en = 1; srch_key = 32'h0000_0AAA;
    @(negedge clk);
    wr_en = 0; srch_en = 0;
    mdl_word[3] = 32'h0000_0BBB;
    chk("R10 old contents", W'(srch_match_vec), W'(e));
    do_search("R10 new contents", 32'h0000_0BBB);
    do_search("R11 setup", 32'h0000_0AAA);
    e = exp_vec(32'h0000_0AAA);
    @(negedge clk);
    srch_en = 1; srch_nxt = 1; srch_key = 32'h0000_0AAA;
    @(negedge clk);
    srch_en = 0; srch_nxt = 0;
    mdl_pend = e;
    chk("R11 vec", W'(srch_match_vec), W'(e));
    chk_out("R11 search wins");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_masked_write();
    t_multi();
    t_zero_mask();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule